// File: doc/BRIEF.md
# HDLC Receiver with Tagged Byte FIFO

This block takes a serial HDLC line, one bit for each cycle in which a bit enable is high. It locks onto flag octets and strips the zeros that the sender inserted after runs of five ones. It also watches for runs of seven ones, which abandon the frame. Each frame's check sequence is verified with the reflected CRC-16/CCITT. Payload bytes go into a 64-entry FIFO. Every entry carries three tags: first byte of frame, last byte of frame, and "frame good". The two check-sequence bytes are never stored.

A host reads through a small register window. Address 0 returns a status byte. Its upper four bits are sticky event flags that clear when this address is read. Its lower four bits describe the FIFO and the byte at its head, and are live. Address 1 returns the head byte and pops it. Frames that hold fewer than four bytes between flags, counting the check sequence, are dropped without trace. Two frames may share one flag.

Top module: `hdlc_rx_tagged`

## Requirements
- R1: Frames are delimited by the flag 0x7E. A frame of fewer than 4 bytes between flags, counting the 2 check bytes, leaves the FIFO and every status bit unchanged.
- R2: Bits arrive LSB first. A 0 that follows five consecutive 1s inside a frame is removed. A data read returns the byte with its first received bit in bit 0.
- R3: If a frame's CRC-16/CCITT (reflected polynomial 0x8408, preset 0xFFFF, good residue 0xF0B8) checks good and no byte of the frame was lost, status bit 4 (valid) is set. The frame's last data byte is tagged with status bit 1 (last) and status bit 2 (good). The two check bytes are not stored.
- R4: If a frame fails the check, status bit 6 is set. Its last byte carries bit 1 but not bit 2.
- R5: Seven consecutive 1s set status bit 7 (abort). Bytes of the current frame not yet stored are discarded, and reception waits for the next flag.
- R6: A push into a full FIFO sets status bit 5 (overrun) and drops the byte. That frame sets neither bit 4 nor the good tag.
- R7: Status bit 3 is high exactly while the FIFO is empty. Status bits 2:0 are 0 while it is empty.
- R8: The first stored byte of a frame shows status bit 0 when it is at the head.
- R9: A read at address 0 clears bits 7:4 and no others. A set in the same cycle wins. A read at address 1 leaves bits 7:4 unchanged.
- R10: A read at address 1 pops the head byte. On an empty FIFO it returns 0x00 and changes nothing.
- R11: Two frames separated by a single shared flag are both received, each with its own tags.
- R12: After reset the status byte reads 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Line bit valid this cycle |
| bitIn | input | 1 | Line bit |
| rdEn | input | 1 | Host read strobe |
| addr | input | 1 | 0: status byte, 1: data byte (pop) |
| rdData | output | 8 | Read data for the selected address |

## Verification
Errors inside the block show up at the ports in a few specific ways. A fault in destuffing or in the bit delay line shows up in the next data byte read. It also corrupts the CRC residue, so the frame ends with bit 6 instead of bit 4, in the same cycle as the closing flag. A fault in the three-byte hold that strips the check bytes shows as extra or missing FIFO entries, or as a last tag on the wrong byte. FIFO pointer faults appear as wrong data or a wrong empty bit at the next read. Sticky clear faults are visible on the second consecutive status read.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  // Strobes from bit-level control to the FIFO/status datapath
  typedef struct packed {
    logic       push;
    logic [7:0] data;
    logic       tagOpen;
    logic       tagClose;
    logic       tagOk;
    logic       setAbort;
    logic       setCrcErr;
    logic       setValid;
  } rxStrobes_t;
endpackage

// File: rtl/hdlc_rx_ctrl.sv
module hdlc_rx_ctrl
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       fifoFull,
  output rxStrobes_t strb
);
  localparam int BCW = $clog2(MIN_BYTES + 1);
  localparam int DLW = 7;  // flag bits that enter the data path before the flag is recognised

  logic [2:0]     onesCnt;
  logic           inFrame;
  logic [DLW-1:0] dl;
  logic [2:0]     dlCnt;
  logic [7:0]     shByte;
  logic [2:0]     bitCnt;
  logic [15:0]    crc;
  logic [7:0]     h0, h1, h2;
  logic [1:0]     heldCnt;
  logic [BCW-1:0] byteCnt;
  logic           firstPending;
  logic           frameOvr;

  logic flagSeen, abortSeen, stuffed, dataValid, exitValid, exitBit, byteDone;
  logic frameEnd, crcGood, pushStream;
  logic [7:0]  newByte;
  logic [15:0] crcNext;

  always_comb begin
    flagSeen   = bitEn && !bitIn && (onesCnt == 3'd6);
    abortSeen  = bitEn &&  bitIn && (onesCnt == 3'd6);
    stuffed    = bitEn && !bitIn && (onesCnt == 3'd5);
    dataValid  = bitEn && inFrame && !flagSeen && !abortSeen && !stuffed;
    exitValid  = dataValid && (dlCnt == 3'(DLW));
    exitBit    = dl[0];
    newByte    = {exitBit, shByte[7:1]};
    byteDone   = exitValid && (bitCnt == 3'd7);
    crcNext    = {1'b0, crc[15:1]} ^ ((crc[0] ^ exitBit) ? CRC_POLY : 16'h0000);
    frameEnd   = flagSeen && inFrame && (byteCnt >= BCW'(MIN_BYTES));
    crcGood    = (crc == CRC_GOOD) && (bitCnt == 3'd0);
    pushStream = byteDone && (heldCnt == 2'd3);

    strb           = '0;
    strb.push      = pushStream || frameEnd;
    strb.data      = h0;
    strb.tagOpen   = firstPending;
    strb.tagClose  = frameEnd;
    strb.tagOk     = frameEnd && crcGood && !frameOvr && !fifoFull;
    strb.setAbort  = abortSeen;
    strb.setCrcErr = frameEnd && !crcGood;
    strb.setValid  = frameEnd && crcGood && !frameOvr && !fifoFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesCnt      <= '0;
      inFrame      <= 1'b0;
      dl           <= '0;
      dlCnt        <= '0;
      shByte       <= '0;
      bitCnt       <= '0;
      crc          <= CRC_PRESET;
      h0           <= '0;
      h1           <= '0;
      h2           <= '0;
      heldCnt      <= '0;
      byteCnt      <= '0;
      firstPending <= 1'b0;
      frameOvr     <= 1'b0;
    end else if (bitEn) begin
      if (bitIn) onesCnt <= (onesCnt == 3'd7) ? 3'd7 : onesCnt + 3'd1;
      else       onesCnt <= '0;

      if (flagSeen) begin
        inFrame      <= 1'b1;
        dlCnt        <= '0;
        bitCnt       <= '0;
        crc          <= CRC_PRESET;
        heldCnt      <= '0;
        byteCnt      <= '0;
        firstPending <= 1'b1;
        frameOvr     <= 1'b0;
      end else if (abortSeen) begin
        inFrame <= 1'b0;
      end else if (dataValid) begin
        dl <= {bitIn, dl[DLW-1:1]};
        if (dlCnt != 3'(DLW)) dlCnt <= dlCnt + 3'd1;
        if (exitValid) begin
          shByte <= newByte;
          bitCnt <= bitCnt + 3'd1;
          crc    <= crcNext;
        end
        if (byteDone) begin
          h0 <= h1;
          h1 <= h2;
          h2 <= newByte;
          if (heldCnt != 2'd3) heldCnt <= heldCnt + 2'd1;
          if (byteCnt < BCW'(MIN_BYTES)) byteCnt <= byteCnt + BCW'(1);
        end
        if (pushStream) begin
          firstPending <= 1'b0;
          if (fifoFull) frameOvr <= 1'b1;
        end
      end
    end
  end

  a_r5_abort_hunts: assert property (@(posedge clk) disable iff (!rstN)
    abortSeen |=> !inFrame);
  a_r1_push_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> inFrame);
  a_r2_no_exit_while_filling: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFrame) |-> !exitValid);
endmodule

// File: rtl/hdlc_rx_dp.sv
module hdlc_rx_dp
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobes_t strb,
  input  logic       rdEn,
  input  logic       addr,
  output logic [7:0] rdData,
  output logic       fifoFull
);
  localparam int AW     = $clog2(DEPTH);
  localparam int EW     = 11;  // {ok, close, open, data[7:0]}
  localparam int NSTICK = 4;   // index 3 abort, 2 crc error, 1 overrun, 0 valid

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   count;
  logic          empty, popReq, pop, wrOk, clearReq;
  logic [EW-1:0] head;
  logic [NSTICK-1:0] sticky, setVec;
  logic [7:0]    status;

  always_comb begin
    fifoFull = (count == (AW+1)'(DEPTH));
    empty    = (count == '0);
    popReq   = rdEn && addr;
    pop      = popReq && !empty;
    wrOk     = strb.push && !fifoFull;
    clearReq = rdEn && !addr;
    head     = mem[rdPtr];
    setVec   = {strb.setAbort, strb.setCrcErr, strb.push && fifoFull, strb.setValid};
    status   = {sticky, empty, empty ? 3'b000 : head[EW-1:8]};
    rdData   = addr ? (empty ? 8'h00 : head[7:0]) : status;
  end

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= {strb.tagOk, strb.tagClose, strb.tagOpen, strb.data};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + AW'(1);
      if (pop)  rdPtr <= rdPtr + AW'(1);
      case ({wrOk, pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < NSTICK; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN)          sticky[i] <= 1'b0;
      else if (setVec[i]) sticky[i] <= 1'b1;
      else if (clearReq)  sticky[i] <= 1'b0;
    end
  end

  a_r6_full_drops: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && fifoFull && !popReq) |=> (count == $past(count)));
  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && fifoFull) |=> sticky[1]);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.setAbort |=> sticky[3]);
  a_r10_empty_pop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty && !strb.push) |=> (count == '0 && $stable(rdPtr)));
  a_r7_empty_status: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> (status[3] && status[2:0] == 3'b000));
endmodule

// File: rtl/hdlc_rx_tagged.sv
module hdlc_rx_tagged
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MIN_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       bitIn,
  input  logic       rdEn,
  input  logic       addr,
  output logic [7:0] rdData
);
  rxStrobes_t strb;
  logic       fifoFull;

  hdlc_rx_ctrl #(.MIN_BYTES(MIN_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn),
    .fifoFull(fifoFull), .strb(strb)
  );

  hdlc_rx_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .addr(addr),
    .rdData(rdData), .fifoFull(fifoFull)
  );
endmodule

// File: tb/hdlc_rx_tagged_tb_top.sv
module hdlc_rx_tagged_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0, bitIn = 1'b0, rdEn = 1'b0, addr = 1'b0;
  logic [7:0] rdData;

  int nChk = 0, nErr = 0, onesRun = 0;
  logic [7:0] pay [0:79];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_rx_tagged dut_i (.clk(clk), .rstN(rstN), .bitEn(bitEn), .bitIn(bitIn),
                        .rdEn(rdEn), .addr(addr), .rdData(rdData));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk); bitEn = 1'b1; bitIn = b;
  endtask

  task automatic lineIdle();
    @(negedge clk); bitEn = 1'b0; bitIn = 1'b0;
  endtask

  task automatic sendFlag();
    sendBit(1'b0);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    sendBit(1'b0);
    onesRun = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sendBit(b[i]);
      if (b[i]) begin
        onesRun++;
        if (onesRun == 5) begin sendBit(1'b0); onesRun = 0; end
      end else onesRun = 0;
    end
  endtask

  task automatic sendBody(input int n, input logic bad);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ pay[k][i];
        c = {1'b0, c[15:1]} ^ (fb ? 16'h8408 : 16'h0000);
      end
      sendByte(pay[k]);
    end
    c = ~c;
    if (bad) c = c ^ 16'h0001;
    sendByte(c[7:0]);
    sendByte(c[15:8]);
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic expStatus(input string req, input logic [7:0] exp);
    logic [7:0] v;
    readReg(1'b0, v);
    check(req, v, exp);
  endtask

  task automatic expData(input string req, input logic [7:0] exp);
    logic [7:0] v;
    readReg(1'b1, v);
    check(req, v, exp);
  endtask

  task automatic testEmptyPop();
    expData("R10 empty pop value", 8'h00);
    expStatus("R10 R7 status after empty pop", 8'h08);
  endtask

  task automatic testGood();
    pay[0] = 8'hA1; pay[1] = 8'hB2; pay[2] = 8'hC3;
    sendFlag(); sendBody(3, 1'b0); sendFlag(); lineIdle();
    expStatus("R3 R8 valid and open", 8'h11);
    expStatus("R9 sticky cleared", 8'h01);
    expData("R2 byte0", 8'hA1);
    expStatus("R8 middle byte untagged", 8'h00);
    expData("R2 byte1", 8'hB2);
    expStatus("R3 last byte close ok", 8'h06);
    expData("R2 byte2", 8'hC3);
    expStatus("R3 fcs not stored", 8'h08);
  endtask

  task automatic testStuff();
    pay[0] = 8'hFF; pay[1] = 8'h7E; pay[2] = 8'h3F; pay[3] = 8'hFC;
    sendFlag(); sendBody(4, 1'b0); sendFlag(); lineIdle();
    expStatus("R2 stuffed frame valid", 8'h11);
    for (int k = 0; k < 4; k++) expData("R2 destuffed byte", pay[k]);
    expStatus("R2 stuffed frame drained", 8'h08);
  endtask

  task automatic testCrcErr();
    pay[0] = 8'h10; pay[1] = 8'h20; pay[2] = 8'h30; pay[3] = 8'h40;
    sendFlag(); sendBody(4, 1'b1); sendFlag(); lineIdle();
    expData("R4 byte0", 8'h10);
    expStatus("R9 data read keeps sticky", 8'h40);
    expStatus("R9 crc sticky cleared", 8'h00);
    expData("R4 byte1", 8'h20);
    expData("R4 byte2", 8'h30);
    expStatus("R4 close without ok", 8'h02);
    expData("R4 byte3", 8'h40);
    expStatus("R4 drained", 8'h08);
  endtask

  task automatic testShort();
    pay[0] = 8'h55;
    sendFlag(); sendBody(1, 1'b0); sendFlag(); lineIdle();
    expStatus("R1 short frame ignored", 8'h08);
  endtask

  task automatic testAbort();
    pay[0] = 8'h11; pay[1] = 8'h22;
    sendFlag(); sendByte(8'h11); sendByte(8'h22);
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    sendFlag(); lineIdle();
    expStatus("R5 abort flagged, nothing stored", 8'h88);
    expStatus("R5 abort cleared", 8'h08);
  endtask

  task automatic testBackToBack();
    pay[0] = 8'h01; pay[1] = 8'h02;
    sendFlag(); sendBody(2, 1'b0);
    pay[0] = 8'h03; pay[1] = 8'h04;
    sendFlag(); sendBody(2, 1'b0); sendFlag(); lineIdle();
    expStatus("R11 first frame head", 8'h11);
    expData("R11 a0", 8'h01);
    expStatus("R11 a1 close ok", 8'h06);
    expData("R11 a1", 8'h02);
    expStatus("R11 b0 open", 8'h01);
    expData("R11 b0", 8'h03);
    expStatus("R11 b1 close ok", 8'h06);
    expData("R11 b1", 8'h04);
    expStatus("R11 drained", 8'h08);
  endtask

  task automatic testOverrun();
    for (int k = 0; k < 70; k++) pay[k] = 8'((k * 37 + 5) & 8'hFF);
    sendFlag(); sendBody(70, 1'b0); sendFlag(); lineIdle();
    expStatus("R6 overrun, no valid", 8'h21);
    expStatus("R6 overrun cleared", 8'h01);
    for (int k = 0; k < 64; k++) expData("R6 kept byte", pay[k]);
    expStatus("R6 only depth bytes kept", 8'h08);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1 v = rdData;
    check("R12 reset status", v, 8'h08);
    testEmptyPop();
    testGood();
    testStuff();
    testCrcErr();
    testShort();
    testAbort();
    testBackToBack();
    testOverrun();
    testGood();
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end
endmodule